// File: doc/BRIEF.md
# Addressed Serial Configuration Port

This block receives configuration words for a frequency-synthesizer core over a three-pin serial link made up of a serial clock, a serial data line and a load strobe. Each 24-bit word is shifted in most-significant bit first. When the load strobe rises, the two low bits of the word pick one of four destination registers. The other 22 bits are copied into that register. The four registers hold the reference divider, the feedback divider (the swallow and main counts), the operating options and an initialization image.

All three serial pins are sampled in the system-clock domain. Each pin passes through a two-stage synchronizer, and rising edges are then detected on the synchronized serial clock and strobe. Writing the initialization register also rewrites the options register and raises a one-cycle counter-reset output. A chip-enable pin works together with a power-down option bit to gate the charge-pump enable. The shift register's top bit is driven out as serial data-out.

Top module: `serial_cfg_port`

## Requirements
- R1: The shift register is 24 bits wide. Each rising edge of `ser_clk` shifts the register left by one and places `ser_dat` in bit 0, so the first bit sent ends in bit 23. `sdo` always shows bit 23 of the register.
- R2: A load with word bits [1:0] = 00 copies word bits [23:2] into `ref_lat`. `ref_div` is word bits [15:2].
- R3: A load with word bits [1:0] = 01 copies word bits [23:2] into `ndiv_lat`. `a_cnt` is word bits [7:2] and `b_cnt` is word bits [20:8].
- R4: A load with word bits [1:0] = 10 copies word bits [23:2] into `func_lat`. The fields are: `pdown` = word bit 2, `mux_sel` = word bits [5:3], `cp_cur1` = word bits [8:6], `cp_cur2` = word bits [11:9], and `presc_sel` = word bits [13:12] (00 gives 8/9, 01 gives 16/17, 10 gives 32/33, 11 gives 64/65).
- R5: A load with word bits [1:0] = 11 copies word bits [23:2] into both `init_lat` and `func_lat`. It also raises `cnt_rst` for exactly one cycle, in the same cycle that the registers change.
- R6: Only a rising edge of `ser_le` transfers data. Holding `ser_le` high while bits are clocked in leaves all four registers unchanged. A load leaves the three registers it does not address untouched.
- R7: `cp_en` is high only while `chip_en` is high and the power-down bit in `func_lat` is clear.
- R8: Register outputs, `sdo` and `cnt_rst` change on the third rising system-clock edge after the serial pin change that causes them.
- R9: After reset, all four registers and `sdo` are zero and `cnt_rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock pin |
| ser_dat | input | 1 | Serial data pin |
| ser_le | input | 1 | Load strobe pin |
| chip_en | input | 1 | Chip enable; low powers the block's analog side down |
| ref_lat | output | 22 | Reference-divider register |
| ndiv_lat | output | 22 | Feedback-divider register |
| func_lat | output | 22 | Options register |
| init_lat | output | 22 | Initialization register |
| ref_div | output | 14 | Reference divide value |
| a_cnt | output | 6 | Swallow count |
| b_cnt | output | 13 | Main count |
| presc_sel | output | 2 | Dual-modulus prescaler select |
| cp_cur1 | output | 3 | Charge-pump current setting 1 |
| cp_cur2 | output | 3 | Charge-pump current setting 2 |
| mux_sel | output | 3 | Monitor output select |
| pdown | output | 1 | Power-down option bit |
| cp_en | output | 1 | Charge-pump enable |
| cnt_rst | output | 1 | One-cycle counter reset pulse |
| sdo | output | 1 | Serial data out |

## Verification
Each pin change reaches its effect on the third system-clock edge. Two edges go to the synchronizer and the third to the register update. `cp_en`, by contrast, follows `chip_en` in the same cycle, because it is combinational. The bench keeps a behavioural model that holds a history of sampled pin values. The model applies each edge event three edges late and is compared with the outputs at every falling clock edge. The bench drives inputs just after a falling edge and samples just before the next one, so every comparison lands between updates. A separate directed check raises the strobe and confirms the old register value after two edges and the new value after three.

// File: rtl/serial_cfg_port.sv
module serial_cfg_port #(
  parameter int WORD_W = 24,
  parameter int ADDR_W = 2,
  parameter int SYNC_W = 2,
  parameter int REF_W  = 14,
  parameter int A_W    = 6,
  parameter int B_W    = 13,
  parameter int CUR_W  = 3,
  parameter int MUX_W  = 3,
  parameter int PRE_W  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ser_clk,
  input  logic                       ser_dat,
  input  logic                       ser_le,
  input  logic                       chip_en,
  output logic [WORD_W-ADDR_W-1:0]   ref_lat,
  output logic [WORD_W-ADDR_W-1:0]   ndiv_lat,
  output logic [WORD_W-ADDR_W-1:0]   func_lat,
  output logic [WORD_W-ADDR_W-1:0]   init_lat,
  output logic [REF_W-1:0]           ref_div,
  output logic [A_W-1:0]             a_cnt,
  output logic [B_W-1:0]             b_cnt,
  output logic [PRE_W-1:0]           presc_sel,
  output logic [CUR_W-1:0]           cp_cur1,
  output logic [CUR_W-1:0]           cp_cur2,
  output logic [MUX_W-1:0]           mux_sel,
  output logic                       pdown,
  output logic                       cp_en,
  output logic                       cnt_rst,
  output logic                       sdo
);
  localparam int PAY_W  = WORD_W - ADDR_W;
  localparam int MUX_LO = 1;
  localparam int C1_LO  = MUX_LO + MUX_W;
  localparam int C2_LO  = C1_LO + CUR_W;
  localparam int PRE_LO = C2_LO + CUR_W;

  typedef enum logic [ADDR_W-1:0] {
    SEL_REF  = 2'b00,
    SEL_NDIV = 2'b01,
    SEL_FUNC = 2'b10,
    SEL_INIT = 2'b11
  } sel_t;

  logic [SYNC_W:0]   clk_s, le_s;
  logic [SYNC_W-1:0] dat_s;
  logic [WORD_W-1:0] shreg;
  logic              clk_rise, le_rise;
  sel_t              sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_s <= '0;
      le_s  <= '0;
      dat_s <= '0;
    end else begin
      clk_s <= {clk_s[SYNC_W-1:0], ser_clk};
      le_s  <= {le_s[SYNC_W-1:0], ser_le};
      dat_s <= {dat_s[SYNC_W-2:0], ser_dat};
    end
  end

  assign clk_rise = clk_s[SYNC_W-1] & ~clk_s[SYNC_W];
  assign le_rise  = le_s[SYNC_W-1]  & ~le_s[SYNC_W];
  assign sel      = sel_t'(shreg[ADDR_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else if (clk_rise) shreg <= {shreg[WORD_W-2:0], dat_s[SYNC_W-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_lat  <= '0;
      ndiv_lat <= '0;
      func_lat <= '0;
      init_lat <= '0;
      cnt_rst  <= 1'b0;
    end else begin
      cnt_rst <= 1'b0;
      if (le_rise) begin
        case (sel)
          SEL_REF:  ref_lat  <= shreg[WORD_W-1:ADDR_W];
          SEL_NDIV: ndiv_lat <= shreg[WORD_W-1:ADDR_W];
          SEL_FUNC: func_lat <= shreg[WORD_W-1:ADDR_W];
          SEL_INIT: begin
            init_lat <= shreg[WORD_W-1:ADDR_W];
            func_lat <= shreg[WORD_W-1:ADDR_W];
            cnt_rst  <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign sdo       = shreg[WORD_W-1];
  assign ref_div   = ref_lat[REF_W-1:0];
  assign a_cnt     = ndiv_lat[A_W-1:0];
  assign b_cnt     = ndiv_lat[A_W+B_W-1:A_W];
  assign pdown     = func_lat[0];
  assign mux_sel   = func_lat[MUX_LO+MUX_W-1:MUX_LO];
  assign cp_cur1   = func_lat[C1_LO+CUR_W-1:C1_LO];
  assign cp_cur2   = func_lat[C2_LO+CUR_W-1:C2_LO];
  assign presc_sel = func_lat[PRE_LO+PRE_W-1:PRE_LO];
  assign cp_en     = chip_en & ~pdown;

  assert_shift_in_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clk_rise |=> shreg[0] == $past(dat_s[SYNC_W-1]));

  assert_hold_no_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !le_rise |=> $stable(ref_lat) && $stable(ndiv_lat) && $stable(func_lat) && $stable(init_lat));

  assert_ref_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (le_rise && sel == SEL_REF) |=> $stable(ndiv_lat) && $stable(func_lat) && $stable(init_lat));

  assert_rst_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst |=> !cnt_rst);

  assert_init_mirror_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rst |-> func_lat == init_lat);

  assert_pd_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pdown || !chip_en) |-> !cp_en);
endmodule

// File: tb/tb_serial_cfg_port.sv
module tb_serial_cfg_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0, chip_en = 1'b1;
  logic [21:0] ref_lat, ndiv_lat, func_lat, init_lat;
  logic [13:0] ref_div;
  logic [5:0]  a_cnt;
  logic [12:0] b_cnt;
  logic [1:0]  presc_sel;
  logic [2:0]  cp_cur1, cp_cur2, mux_sel;
  logic        pdown, cp_en, cnt_rst, sdo;

  int total = 0, bad = 0, cycles = 0, rst_pulses = 0;
  bit done = 0, live = 0;

  always #2 clk = ~clk;

  serial_cfg_port dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
    .chip_en(chip_en), .ref_lat(ref_lat), .ndiv_lat(ndiv_lat), .func_lat(func_lat),
    .init_lat(init_lat), .ref_div(ref_div), .a_cnt(a_cnt), .b_cnt(b_cnt),
    .presc_sel(presc_sel), .cp_cur1(cp_cur1), .cp_cur2(cp_cur2), .mux_sel(mux_sel),
    .pdown(pdown), .cp_en(cp_en), .cnt_rst(cnt_rst), .sdo(sdo));

  // behavioural reference: pin history, events applied three edges late
  bit q_c[$], q_d[$], q_l[$];
  logic [23:0] m_sh;
  logic [21:0] m_ref, m_nd, m_fn, m_in;
  logic        m_cr;

  always @(posedge clk) begin
    if (!rst_n) begin
      q_c = {0, 0, 0}; q_d = {0, 0, 0}; q_l = {0, 0, 0};
      m_sh = 0; m_ref = 0; m_nd = 0; m_fn = 0; m_in = 0; m_cr = 0;
    end else begin
      q_c.push_front(ser_clk); q_d.push_front(ser_dat); q_l.push_front(ser_le);
      m_cr = 0;
      if (q_l[2] && !q_l[3]) begin
        if (m_sh[1:0] == 2'd0) m_ref = m_sh[23:2];
        else if (m_sh[1:0] == 2'd1) m_nd = m_sh[23:2];
        else if (m_sh[1:0] == 2'd2) m_fn = m_sh[23:2];
        else begin m_in = m_sh[23:2]; m_fn = m_sh[23:2]; m_cr = 1; end
      end
      if (q_c[2] && !q_c[3]) m_sh = {m_sh[22:0], q_d[2]};
      void'(q_c.pop_back()); void'(q_d.pop_back()); void'(q_l.pop_back());
      if (cnt_rst) rst_pulses++;
    end
  end

  task automatic report();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      report();
    end
  end

  // R8: per-cycle comparison against the model
  always @(negedge clk) begin
    if (live && rst_n) begin
      total++;
      if ({ref_lat, ndiv_lat, func_lat, init_lat, cnt_rst, sdo, cp_en} !==
          {m_ref, m_nd, m_fn, m_in, m_cr, m_sh[23], chip_en & ~m_fn[0]}) begin
        bad++;
        $display("FAIL R8 model t=%0t: actual=%h/%h/%h/%h cr=%b sdo=%b cp=%b expected=%h/%h/%h/%h cr=%b sdo=%b cp=%b",
          $time, ref_lat, ndiv_lat, func_lat, init_lat, cnt_rst, sdo, cp_en,
          m_ref, m_nd, m_fn, m_in, m_cr, m_sh[23], chip_en & ~m_fn[0]);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic shift_word(input logic [23:0] w);
    for (int i = 23; i >= 0; i--) begin
      ser_dat = w[i]; step(3);
      ser_clk = 1'b1; step(3);
      ser_clk = 1'b0;
    end
    step(3);
  endtask

  task automatic pulse_le();
    ser_le = 1'b1; step(3);
    ser_le = 1'b0; step(4);
  endtask

  task automatic send(input logic [23:0] w);
    shift_word(w);
    pulse_le();
  endtask

  initial begin
    logic [23:0] w_ref, w_n, w_f, w_i, w_f0, w_x, w_r2;
    logic [21:0] s_ref, s_nd, s_fn, s_in;
    int p0;
    w_ref = {8'hC3, 14'd12345, 2'b00};
    w_n   = {3'b101, 13'd891, 6'd63, 2'b01};
    w_f   = {10'h155, 2'b10, 3'd5, 3'd3, 3'd6, 1'b0, 2'b10};
    w_i   = {10'h0AA, 2'b01, 3'd2, 3'd7, 3'd1, 1'b1, 2'b11};
    w_f0  = {10'h3FF, 2'b11, 3'd1, 3'd4, 3'd2, 1'b0, 2'b10};
    w_x   = {22'h2ABCDE, 2'b00};
    w_r2  = {8'h5A, 14'd16383, 2'b00};

    step(3);
    rst_n = 1'b1;
    step(1);
    live = 1;
    @(negedge clk);
    chk({ref_lat, ndiv_lat, func_lat, init_lat} == 0, "R9 latches zero", {10'd0, ref_lat}, 0);
    chk(sdo == 0 && cnt_rst == 0, "R9 sdo/cnt_rst low", {sdo, cnt_rst}, 0);
    chk(cp_en == 1, "R7 cp_en after reset", cp_en, 1);
    #1;

    send(w_ref);
    chk(ref_div == 14'd12345, "R2 ref_div", ref_div, 14'd12345);
    chk(ref_lat == w_ref[23:2], "R2 ref_lat", ref_lat, w_ref[23:2]);
    chk(sdo == w_ref[23], "R1 sdo is first bit sent", sdo, w_ref[23]);

    send(w_n);
    chk(a_cnt == 6'd63 && b_cnt == 13'd891, "R3 a/b counts", {a_cnt, b_cnt}, {6'd63, 13'd891});
    chk(ref_lat == w_ref[23:2], "R6 ref untouched by N load", ref_lat, w_ref[23:2]);
    chk(sdo == w_n[23], "R1 sdo after second word", sdo, w_n[23]);

    p0 = rst_pulses;
    send(w_f);
    chk({presc_sel, cp_cur2, cp_cur1, mux_sel, pdown} == {2'b10, 3'd5, 3'd3, 3'd6, 1'b0}, "R4 fields",
        {presc_sel, cp_cur2, cp_cur1, mux_sel, pdown}, {2'b10, 3'd5, 3'd3, 3'd6, 1'b0});
    chk(rst_pulses == p0, "R4 no counter reset", rst_pulses, p0);
    chk(init_lat == 0, "R6 init untouched by function load", init_lat, 0);

    p0 = rst_pulses;
    send(w_i);
    chk(init_lat == w_i[23:2] && func_lat == w_i[23:2], "R5 init mirrored", func_lat, w_i[23:2]);
    chk(rst_pulses == p0 + 1, "R5 single cnt_rst", rst_pulses, p0 + 1);
    chk(cp_en == 0, "R7 power-down bit gates cp_en", cp_en, 0);

    send(w_f0);
    chk(cp_en == 1, "R7 cp_en restored", cp_en, 1);
    chip_en = 1'b0; step(1);
    chk(cp_en == 0, "R7 chip_en low", cp_en, 0);
    chip_en = 1'b1; step(1);
    chk(cp_en == 1, "R7 chip_en high", cp_en, 1);

    ser_le = 1'b1; step(4);
    s_ref = ref_lat; s_nd = ndiv_lat; s_fn = func_lat; s_in = init_lat;
    shift_word(w_x);
    chk({ref_lat, ndiv_lat, func_lat, init_lat} == {s_ref, s_nd, s_fn, s_in}, "R6 clocking with strobe high",
        {10'd0, ref_lat}, {10'd0, s_ref});
    ser_le = 1'b0; step(4);
    chk(ref_lat == s_ref, "R6 strobe fall no transfer", ref_lat, s_ref);
    pulse_le();
    chk(ref_lat == w_x[23:2], "R6 rising strobe transfers", ref_lat, w_x[23:2]);

    shift_word(w_r2);
    ser_le = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(ref_lat == w_x[23:2], "R8 old value after two edges", ref_lat, w_x[23:2]);
    @(negedge clk);
    chk(ref_lat == w_r2[23:2], "R8 new value on third edge", ref_lat, w_r2[23:2]);
    #1; ser_le = 1'b0; step(6);
    chk(ref_div == 14'd16383, "R2 max reference divide", ref_div, 14'd16383);

    step(4);
    report();
  end
endmodule